// File: doc/BRIEF.md
# Writeback Frame Capture Controller

This block is the control unit of a display writeback engine. Software programs a destination base address, a line pitch in bytes and the frame dimensions through a small register port, then sets a self-clearing start bit. The unit then follows the incoming pixel stream one line at a time. Each time the stream signals that a full line has arrived, the unit issues one memory write request for that line at the base address plus the line index times the pitch. It holds the request until the memory side acknowledges it.

A progress register counts the lines committed to memory. A busy flag shows that a frame is in flight. Writing the abort bit ends the frame at once and cuts off further writes. When the engine goes idle after a frame, the interrupt output rises if its enable bit is set. Software acknowledges it by writing that enable bit low. A build parameter selects whether the dimension fields hold the true line count or the count minus one.

Top module: `wbcap_ctrl`

## Requirements
- R1: After reset, the base, pitch, dimension and progress registers read 0, the control register reads 0x5440_0000, and busy, irq and mem_req are low.
- R2: Writes force alignment on two registers. The base register (offset 0x00) reads back with bits 1:0 cleared. The pitch register (offset 0x04) reads back with bits 3:0 cleared.
- R3: The dimension register (offset 0x08) stores the height in bits 31:16 and the width in bits 15:0, and reads back as written.
- R4: The control register (offset 0x0C) always reads bits 31:24 as 0x54 and bits 23:22 as 01. It reads bit 1 as the busy flag and bit 2 as the interrupt enable. The start bit (bit 0) and the abort bit (bit 14) always read 0.
- R5: When the engine is idle, a control write with bit 0 set starts a frame. From the next cycle busy reads 1 and the progress register (offset 0x10) reads 0.
- R6: Line n of a frame is written at base + n*pitch. mem_req stays high with a stable mem_addr until mem_ack, and progress increments by one on each acknowledge.
- R7: The frame ends after the last line is acknowledged, and busy then reads 0. With DIM_MINUS_ONE=0 the frame has height lines. With DIM_MINUS_ONE=1 it has height+1 lines.
- R8: irq is high exactly when the interrupt enable (control bit 2) is set and the engine has finished a frame (ended or aborted) since the last start. Writing bit 2 low drops irq, and a new start drops it too.
- R9: A start request while busy is ignored. The frame keeps its progress count and its address sequence.
- R10: A control write with bit 14 set during a frame makes busy and mem_req low from the next cycle. Further line arrivals issue no requests, and the frame counts as finished for R8.
- R11: Base, pitch and line count are captured at start. Register writes during a frame do not change its addresses or its length.
- R12: With DIM_MINUS_ONE=0, a start with height 0 finishes at once, issues no write request and leaves busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| line_done | input | 1 | A full line of the pixel stream has arrived |
| mem_req | output | 1 | Line write request |
| mem_addr | output | AW | Destination address of the requested line |
| mem_ack | input | 1 | Memory accepts the current request |
| irq | output | 1 | Level interrupt: enabled and idle after a frame |

## Verification
The assertions assume that mem_ack is only raised while mem_req is high. They also assume that line_done is only pulsed while a frame waits for its next line, so a pulse never lands during an outstanding request. They assume that an abort write never coincides with an acknowledge, and that the register port is driven with a full word per write. The directed stimulus keeps to this. Each task pulses line_done only after the previous request has been acknowledged. It acknowledges only after it has seen mem_req high. It issues aborts while a request is pending and unacknowledged. The one deliberate stray line pulse comes after an abort or a zero-line start, when the engine is idle and must ignore it.

// File: rtl/wbcap_pkg.sv
package wbcap_pkg;
    localparam int REG_W       = 32;
    localparam int OFF_BASE    = 'h00;
    localparam int OFF_PITCH   = 'h04;
    localparam int OFF_DIM     = 'h08;
    localparam int OFF_CTRL    = 'h0C;
    localparam int OFF_PROG    = 'h10;
    localparam int BIT_GO      = 0;
    localparam int BIT_BUSY    = 1;
    localparam int BIT_IE      = 2;
    localparam int BIT_ABORT   = 14;
    localparam logic [7:0] PILOT_ID = 8'h54;
    localparam logic [1:0] VERSION_ID = 2'b01;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_REQ  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/wbcap_regs.sv
module wbcap_regs
    import wbcap_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int AW     = 32,
    parameter int DIM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [AW-1:0]     base,
    output logic [AW-1:0]     pitch,
    output logic [DIM_W-1:0]  height,
    output logic [DIM_W-1:0]  width,
    output logic              ie,
    output logic              go,
    output logic              abort
);
    typedef struct packed {
        logic [AW-1:0]    base;
        logic [AW-1:0]    pitch;
        logic [DIM_W-1:0] height;
        logic [DIM_W-1:0] width;
        logic             ie;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic sel_ctrl;

    assign sel_ctrl = we && (addr == ADDR_W'(OFF_CTRL));

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (addr == ADDR_W'(OFF_BASE))
                cfg_d.base = {wdata[AW-1:2], 2'b00};
            if (addr == ADDR_W'(OFF_PITCH))
                cfg_d.pitch = {wdata[AW-1:4], 4'b0000};
            if (addr == ADDR_W'(OFF_DIM)) begin
                cfg_d.height = wdata[16 +: DIM_W];
                cfg_d.width  = wdata[0 +: DIM_W];
            end
        end
        if (sel_ctrl)
            cfg_d.ie = wdata[BIT_IE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign base   = cfg_q.base;
    assign pitch  = cfg_q.pitch;
    assign height = cfg_q.height;
    assign width  = cfg_q.width;
    assign ie     = cfg_q.ie;
    assign go     = sel_ctrl && wdata[BIT_GO];
    assign abort  = sel_ctrl && wdata[BIT_ABORT];
endmodule

// File: rtl/wbcap_seq.sv
module wbcap_seq
    import wbcap_pkg::*;
#(
    parameter int AW            = 32,
    parameter int DIM_W         = 16,
    parameter bit DIM_MINUS_ONE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             abort,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    pitch,
    input  logic [DIM_W-1:0] height,
    input  logic             line_done,
    input  logic             mem_ack,
    output logic             busy,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic [DIM_W:0]   progress,
    output logic             done
);
    localparam int CNT_W = DIM_W + 1;

    typedef struct packed {
        seq_state_e       state;
        logic [AW-1:0]    addr;
        logic [AW-1:0]    pitch;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] count;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] lines_req;
    logic [CNT_W-1:0] count_inc;

    generate
        if (DIM_MINUS_ONE) begin : g_minus_one
            assign lines_req = {1'b0, height} + CNT_W'(1);
        end else begin : g_true_count
            assign lines_req = {1'b0, height};
        end
    endgenerate

    assign count_inc = s_q.count + CNT_W'(1);

    always_comb begin
        s_d = s_q;
        case (s_q.state)
            SEQ_IDLE: begin
                if (go) begin
                    s_d.count = '0;
                    s_d.addr  = base;
                    s_d.pitch = pitch;
                    s_d.total = lines_req;
                    if (lines_req == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.done  = 1'b0;
                        s_d.state = SEQ_WAIT;
                    end
                end
            end
            SEQ_WAIT: begin
                if (line_done)
                    s_d.state = SEQ_REQ;
            end
            SEQ_REQ: begin
                if (mem_ack) begin
                    s_d.count = count_inc;
                    s_d.addr  = s_q.addr + s_q.pitch;
                    if (count_inc == s_q.total) begin
                        s_d.state = SEQ_IDLE;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.state = SEQ_WAIT;
                    end
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
        if (abort && (s_q.state != SEQ_IDLE)) begin
            s_d.state = SEQ_IDLE;
            s_d.count = s_q.count;
            s_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: SEQ_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy     = (s_q.state != SEQ_IDLE);
    assign mem_req  = (s_q.state == SEQ_REQ);
    assign mem_addr = s_q.addr;
    assign progress = s_q.count;
    assign done     = s_q.done;
endmodule

// File: rtl/wbcap_ctrl.sv
module wbcap_ctrl
    import wbcap_pkg::*;
#(
    parameter int ADDR_W        = 5,
    parameter int AW            = 32,
    parameter int DIM_W         = 16,
    parameter bit DIM_MINUS_ONE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              line_done,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_ack,
    output logic              irq
);
    logic [AW-1:0]    base_w, pitch_w;
    logic [DIM_W-1:0] height_w, width_w;
    logic             ie_w, go_w, abort_w;
    logic             busy_w, done_w;
    logic [DIM_W:0]   prog_w;

    wbcap_regs #(.ADDR_W(ADDR_W), .AW(AW), .DIM_W(DIM_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .base   (base_w),
        .pitch  (pitch_w),
        .height (height_w),
        .width  (width_w),
        .ie     (ie_w),
        .go     (go_w),
        .abort  (abort_w)
    );

    wbcap_seq #(.AW(AW), .DIM_W(DIM_W), .DIM_MINUS_ONE(DIM_MINUS_ONE)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go_w),
        .abort     (abort_w),
        .base      (base_w),
        .pitch     (pitch_w),
        .height    (height_w),
        .line_done (line_done),
        .mem_ack   (mem_ack),
        .busy      (busy_w),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .progress  (prog_w),
        .done      (done_w)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(OFF_BASE):  reg_rdata = 32'(base_w);
            ADDR_W'(OFF_PITCH): reg_rdata = 32'(pitch_w);
            ADDR_W'(OFF_DIM):   reg_rdata = {16'(height_w), 16'(width_w)};
            ADDR_W'(OFF_CTRL): begin
                reg_rdata[31:24]    = PILOT_ID;
                reg_rdata[23:22]    = VERSION_ID;
                reg_rdata[BIT_IE]   = ie_w;
                reg_rdata[BIT_BUSY] = busy_w;
            end
            ADDR_W'(OFF_PROG):  reg_rdata = 32'(prog_w);
            default:            reg_rdata = '0;
        endcase
    end

    assign irq = ie_w && done_w;
endmodule

// File: rtl/wbcap_ctrl_chk.sv
module wbcap_ctrl_chk
    import wbcap_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int AW     = 32,
    parameter int PW     = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [AW-1:0]     mem_addr,
    input logic              busy,
    input logic              irq,
    input logic              ie,
    input logic [PW-1:0]     progress
);
    logic abort_wr;
    assign abort_wr = reg_we && (reg_addr == ADDR_W'(OFF_CTRL)) && reg_wdata[BIT_ABORT];

    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !abort_wr |=> mem_req && $stable(mem_addr));

    a_r6_progress_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !abort_wr |=> progress == $past(progress) + PW'(1));

    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        busy && abort_wr |=> !busy && !mem_req);

    a_r8_irq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ie && !busy);

    a_r7_req_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !abort_wr && !(mem_req && mem_ack) |=> busy);
endmodule

bind wbcap_ctrl wbcap_ctrl_chk #(.ADDR_W(ADDR_W), .AW(AW), .PW(DIM_W + 1)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .busy      (busy_w),
    .irq       (irq),
    .ie        (ie_w),
    .progress  (prog_w)
);

// File: tb/wbcap_ctrl_tb.sv
`timescale 1ns/1ps
module wbcap_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        line_done = 1'b0;
    logic        mem_ack = 1'b0;
    logic        use_m1 = 1'b0;
    logic [31:0] rdata_a, rdata_b, addr_a, addr_b;
    logic        req_a, req_b, irq_a, irq_b;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    wbcap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_a), .line_done(line_done),
        .mem_req(req_a), .mem_addr(addr_a), .mem_ack(mem_ack), .irq(irq_a)
    );

    wbcap_ctrl #(.DIM_MINUS_ONE(1'b1)) u_dut_m1 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .line_done(line_done),
        .mem_req(req_b), .mem_addr(addr_b), .mem_ack(mem_ack), .irq(irq_b)
    );

    wire [31:0] rdata = use_m1 ? rdata_b : rdata_a;
    wire [31:0] maddr = use_m1 ? addr_b : addr_a;
    wire        mreq  = use_m1 ? req_b : req_a;
    wire        irq   = use_m1 ? irq_b : irq_a;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse_line();
        @(negedge clk); line_done = 1'b1;
        @(negedge clk); line_done = 1'b0;
    endtask

    task automatic do_line(input string req, input logic [31:0] exp_addr, input logic [31:0] exp_prog);
        logic [31:0] v;
        pulse_line();
        chk({req, " R6 req"}, {31'b0, mreq}, 32'd1);
        chk({req, " R6 addr"}, maddr, exp_addr);
        @(negedge clk);
        chk({req, " R6 hold"}, {31'b0, mreq}, 32'd1);
        chk({req, " R6 hold addr"}, maddr, exp_addr);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        chk({req, " R6 req drop"}, {31'b0, mreq}, 32'd0);
        rd(5'h10, v);
        chk({req, " R6 progress"}, v, exp_prog);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(5'h00, v); chk("R1 base", v, 32'h0);
        rd(5'h04, v); chk("R1 pitch", v, 32'h0);
        rd(5'h08, v); chk("R1 dim", v, 32'h0);
        rd(5'h0C, v); chk("R1 ctrl", v, 32'h5440_0000);
        rd(5'h10, v); chk("R1 progress", v, 32'h0);
        chk("R1 outputs", {29'b0, mreq, irq, 1'b0}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(5'h00, 32'h1000_0007); rd(5'h00, v); chk("R2 base align", v, 32'h1000_0004);
        wr(5'h04, 32'h0000_013F); rd(5'h04, v); chk("R2 pitch align", v, 32'h0000_0130);
        wr(5'h08, 32'h0003_0280); rd(5'h08, v); chk("R3 dim fields", v, 32'h0003_0280);
        wr(5'h0C, 32'h0000_0004); rd(5'h0C, v); chk("R4 ctrl ie", v, 32'h5440_0004);
        chk("R8 no irq before frame", {31'b0, irq}, 32'd0);
        wr(5'h0C, 32'h0000_0000);
    endtask

    task automatic t_frame();
        logic [31:0] v;
        wr(5'h00, 32'h8000_0000);
        wr(5'h04, 32'h0000_0100);
        wr(5'h08, 32'h0003_0010);
        wr(5'h0C, 32'h0000_0005);
        rd(5'h0C, v); chk("R4 R5 busy, go self-clear", v, 32'h5440_0006);
        rd(5'h10, v); chk("R5 progress zero", v, 32'h0);
        chk("R8 irq low while busy", {31'b0, irq}, 32'd0);
        for (int n = 0; n < 3; n++)
            do_line("R6", 32'h8000_0000 + 32'(n) * 32'h100, 32'(n + 1));
        rd(5'h0C, v); chk("R7 idle after last line", v[1] ? 32'd1 : 32'd0, 32'd0);
        chk("R8 irq at end", {31'b0, irq}, 32'd1);
        wr(5'h0C, 32'h0000_0000);
        chk("R8 irq cleared by ie low", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_busy_writes();
        logic [31:0] v;
        wr(5'h00, 32'h0000_2000);
        wr(5'h04, 32'h0000_0040);
        wr(5'h08, 32'h0002_0010);
        wr(5'h0C, 32'h0000_0001);
        rd(5'h10, v); chk("R5 progress cleared at restart", v, 32'h0);
        do_line("R11", 32'h0000_2000, 32'd1);
        wr(5'h00, 32'h0000_9000);
        wr(5'h04, 32'h0000_0080);
        wr(5'h08, 32'h0005_0010);
        wr(5'h0C, 32'h0000_0001);
        rd(5'h0C, v); chk("R9 still busy", {31'b0, v[1]}, 32'd1);
        rd(5'h10, v); chk("R9 progress kept", v, 32'd1);
        do_line("R11 R9", 32'h0000_2040, 32'd2);
        rd(5'h0C, v); chk("R11 length captured", {31'b0, v[1]}, 32'd0);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        wr(5'h00, 32'h0000_4000);
        wr(5'h04, 32'h0000_0020);
        wr(5'h08, 32'h0004_0010);
        wr(5'h0C, 32'h0000_0005);
        pulse_line();
        chk("R10 req before abort", {31'b0, mreq}, 32'd1);
        wr(5'h0C, 32'h0000_4004);
        chk("R10 req dropped", {31'b0, mreq}, 32'd0);
        rd(5'h0C, v); chk("R10 ctrl after abort", v, 32'h5440_0004);
        chk("R10 R8 irq after abort", {31'b0, irq}, 32'd1);
        pulse_line();
        chk("R10 no request after abort", {31'b0, mreq}, 32'd0);
        rd(5'h10, v); chk("R10 progress", v, 32'd0);
        wr(5'h0C, 32'h0000_0000);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        wr(5'h08, 32'h0000_0010);
        wr(5'h0C, 32'h0000_0005);
        rd(5'h0C, v); chk("R12 not busy", {31'b0, v[1]}, 32'd0);
        chk("R12 irq", {31'b0, irq}, 32'd1);
        pulse_line();
        chk("R12 no request", {31'b0, mreq}, 32'd0);
        wr(5'h0C, 32'h0000_0000);
    endtask

    task automatic t_minus_one();
        logic [31:0] v;
        wr(5'h0C, 32'h0000_4000);
        use_m1 = 1'b1;
        wr(5'h00, 32'h0000_3000);
        wr(5'h04, 32'h0000_0010);
        wr(5'h08, 32'h0001_0010);
        wr(5'h0C, 32'h0000_0001);
        do_line("R7 m1", 32'h0000_3000, 32'd1);
        rd(5'h0C, v); chk("R7 m1 busy after first", {31'b0, v[1]}, 32'd1);
        do_line("R7 m1", 32'h0000_3010, 32'd2);
        rd(5'h0C, v); chk("R7 m1 idle after second", {31'b0, v[1]}, 32'd0);
        use_m1 = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_frame();
        t_busy_writes();
        t_abort();
        t_zero();
        t_minus_one();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule